// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

A purely combinational 32-bit arithmetic and logic unit for the execute stage of a simple load/store processor. It takes two operands and a 4-bit operation code and returns a 32-bit result, a flag that is high when the result is all zeros, and a signed overflow flag. Operand extension, shifts, multiplication and division are handled elsewhere in the datapath.

Addition, subtraction and both less-than comparisons use one shared carry chain. For subtraction and comparisons, the second operand is inverted and the carry input is forced to one. The two comparisons read their answer from that chain: the signed one from the difference's sign bit corrected by overflow, the unsigned one from the carry out. An input lets the decoder silence overflow reporting for the unsigned instruction variants. The equality branch test uses the zero flag after a subtraction.

Top module: `int_alu`

## Requirements
- R1: Operation code 0000 (add) returns the sum of the two operands modulo 2^32.
- R2: Operation code 0001 (subtract) returns the first operand minus the second, modulo 2^32.
- R3: Codes 0010, 0011, 0100 and 0101 return the bitwise AND, OR, XOR and NOR of the operands.
- R4: Code 0110 (signed less-than) returns 1 in bit 0 when the first operand is below the second as two's complement values, else 0. Bits 31..1 are always zero, and the answer stays correct when the internal difference overflows.
- R5: Code 0111 (unsigned less-than) returns 1 in bit 0 when the first operand is below the second as unsigned values, else 0, with bits 31..1 zero. For example, 0xFFFFFFFF against 0x00000001 gives 0 here and 1 under R4.
- R6: The zero flag is high exactly when all 32 result bits are zero, for every operation code.
- R7: For add, the overflow flag rises when two non-negative operands give a negative sum, or two negative operands give a non-negative sum.
- R8: For subtract, the overflow flag rises when a non-negative minus a negative gives a negative, or a negative minus a non-negative gives a non-negative.
- R9: When the suppress input is high, the overflow flag is low for every code, and the result is unchanged.
- R10: Codes 1000 to 1111 return a zero result with the overflow flag low, so the zero flag is high.
- R11: The logic and comparison codes never raise the overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op_code | input | 4 | Operation select |
| ovf_quiet | input | 1 | High to suppress overflow reporting |
| res | output | 32 | Result word |
| res_zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The zero flag and the overflow flag can be raised by the same operation. Adding 0x80000000 to itself wraps to zero and overflows, and subtracting 0x80000000 from 0x80000000... is not such a case, because it gives zero without overflow. The bench drives these overflow-to-zero add cases with and without suppression and checks both flags against a 64-bit signed reference model. The same mechanism is provoked on signed less-than with operands whose difference overflows. There, the bench checks that the comparison result follows true signed order and that no overflow is reported.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       op_code,
  input  logic             ovf_quiet,
  output logic [WIDTH-1:0] res,
  output logic             res_zero,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  localparam logic [3:0] OP_ADD  = 4'b0000;
  localparam logic [3:0] OP_SUB  = 4'b0001;
  localparam logic [3:0] OP_AND  = 4'b0010;
  localparam logic [3:0] OP_OR   = 4'b0011;
  localparam logic [3:0] OP_XOR  = 4'b0100;
  localparam logic [3:0] OP_NOR  = 4'b0101;
  localparam logic [3:0] OP_SLT  = 4'b0110;
  localparam logic [3:0] OP_SLTU = 4'b0111;

  logic             negate;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] sum;
  logic             carry_out;
  logic             sum_ovf;
  logic             lt_signed;
  logic             lt_unsigned;

  assign negate = (op_code == OP_SUB) || (op_code == OP_SLT) || (op_code == OP_SLTU);
  assign b_eff  = negate ? ~opb : opb;
  assign chain  = {1'b0, opa} + {1'b0, b_eff} + {{WIDTH{1'b0}}, negate};
  assign sum       = chain[WIDTH-1:0];
  assign carry_out = chain[WIDTH];

  assign sum_ovf     = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);
  assign lt_signed   = sum[MSB] ^ sum_ovf;
  assign lt_unsigned = ~carry_out;

  always_comb begin
    case (op_code)
      OP_ADD,
      OP_SUB:  res = sum;
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_XOR:  res = opa ^ opb;
      OP_NOR:  res = ~(opa | opb);
      OP_SLT:  res = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU: res = {{(WIDTH-1){1'b0}}, lt_unsigned};
      default: res = '0;
    endcase
  end

  assign res_zero = ~|res;
  assign ovf      = sum_ovf && !ovf_quiet && ((op_code == OP_ADD) || (op_code == OP_SUB));

  always_comb begin
    if (op_code == OP_SLT || op_code == OP_SLTU)
      AST_CMP_UPPER_CLEAR: assert (res[MSB:1] == '0) else $error("compare upper bits"); // R4
    if (op_code[3])
      AST_UNUSED_QUIET: assert (res == '0 && !ovf && res_zero) else $error("unused code"); // R10
    if (ovf_quiet)
      AST_NO_OVERFLOW: assert (!ovf) else $error("suppressed overflow seen"); // R9
    if (ovf && op_code == OP_ADD)
      AST_ADD_OVF_SIGNS: assert (opa[MSB] == opb[MSB] && res[MSB] != opa[MSB]) else $error("add ovf"); // R7
    if (ovf && op_code == OP_SUB)
      AST_SUB_OVF_SIGNS: assert (opa[MSB] != opb[MSB] && res[MSB] != opa[MSB]) else $error("sub ovf"); // R8
    if (op_code == OP_SLT && opa == opb)
      AST_SLT_EQUAL: assert (res_zero) else $error("slt equal"); // R4
    if (op_code >= OP_AND && op_code <= OP_SLTU)
      AST_LOGIC_NO_OVF: assert (!ovf) else $error("logic ovf"); // R11
  end

endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [3:0]  op_code = '0;
  logic        ovf_quiet = 1'b0;
  logic [31:0] res;
  logic        res_zero;
  logic        ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  int_alu u_dut (
    .opa(opa), .opb(opb), .op_code(op_code), .ovf_quiet(ovf_quiet),
    .res(res), .res_zero(res_zero), .ovf(ovf)
  );

  function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic q, output logic [31:0] r, output logic v);
    longint sa, sb, s;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = '0;
    v = 1'b0;
    case (op)
      4'd0: begin s = sa + sb; r = s[31:0]; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd1: begin s = sa - sb; r = s[31:0]; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = ~(a | b);
      4'd6: r = {31'd0, sa < sb};
      4'd7: r = {31'd0, a < b};
      default: r = '0;
    endcase
    if (q) v = 1'b0;
  endfunction

  task automatic apply(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic q);
    logic [31:0] er;
    logic ev;
    @(negedge clk);
    op_code = op; opa = a; opb = b; ovf_quiet = q;
    #1;
    model(op, a, b, q, er, ev);
    n_tests++;
    if (res !== er || res_zero !== (er == 0) || ovf !== ev) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h q=%0b: res=%h z=%0b v=%0b expected res=%h z=%0b v=%0b",
               tag, op, a, b, q, res, res_zero, ovf, er, (er == 0), ev);
    end
  endtask

  task automatic t_reset;
    apply("R6 R1 idle", 4'd0, 32'd0, 32'd0, 1'b0);
  endtask

  task automatic t_add; // R1 R7
    apply("R1", 4'd0, 32'd7, 32'd3, 1'b0);
    apply("R1", 4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0);
    apply("R7 pos", 4'd0, 32'h7FFF_FFFF, 32'd1, 1'b0);
    apply("R7 neg", 4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    apply("R7 mixed", 4'd0, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
  endtask

  task automatic t_sub; // R2 R8
    apply("R2", 4'd1, 32'd7, 32'd6, 1'b0);
    apply("R2", 4'd1, 32'd3, 32'd5, 1'b0);
    apply("R8 pos-neg", 4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    apply("R8 neg-pos", 4'd1, 32'h8000_0000, 32'd1, 1'b0);
    apply("R8 R6 equal", 4'd1, 32'h1234_5678, 32'h1234_5678, 1'b0);
  endtask

  task automatic t_logic; // R3 R11
    for (int k = 2; k <= 5; k++) begin
      apply("R3 R11", 4'(k), 32'hC5C5_00FF, 32'h0F0F_0F0F, 1'b0);
      apply("R3 R11", 4'(k), 32'hFFFF_FFFF, 32'h0000_0000, 1'b0);
    end
    apply("R3 R6 and-zero", 4'd2, 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
  endtask

  task automatic t_compare; // R4 R5 R11
    apply("R4 neg<pos", 4'd6, 32'hFFFF_FFFF, 32'd1, 1'b0);
    apply("R5 big>1", 4'd7, 32'hFFFF_FFFF, 32'd1, 1'b0);
    apply("R4 ovf path", 4'd6, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
    apply("R4 ovf path2", 4'd6, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
    apply("R4 equal", 4'd6, 32'd9, 32'd9, 1'b0);
    apply("R5 small", 4'd7, 32'd2, 32'd9, 1'b0);
    apply("R5 equal", 4'd7, 32'd9, 32'd9, 1'b0);
  endtask

  task automatic t_quiet; // R9 R6
    apply("R9 add", 4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1);
    apply("R9 sub", 4'd1, 32'h8000_0000, 32'd1, 1'b1);
    apply("R6 R7 zero+ovf", 4'd0, 32'h8000_0000, 32'h8000_0000, 1'b0);
    apply("R9 R6 zero quiet", 4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1);
  endtask

  task automatic t_unused; // R10
    for (int k = 8; k <= 15; k++)
      apply("R10", 4'(k), 32'h8000_0000, 32'h8000_0000, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_compare();
    t_quiet();
    t_unused();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule